// File: doc/BRIEF.md
# Load-Use Stall Detector

This unit sits between the fetch and decode stages of a five-stage integer pipeline. Each cycle it looks at the instruction held in the fetch/decode pipeline register and at the instruction one stage ahead, in the decode/execute register. When the instruction ahead is a load and the instruction behind it reads that load's destination register, the loaded value cannot be forwarded in time. The unit then asks the pipeline to hold for one cycle.

The unit is purely combinational and has no clock or reset. Only register-reading consumers of the register, store and branch classes are examined; every other opcode passes through without a hold. On a hazard it raises three separate hold flags, one for the instruction path, one for the PC path and one for the control path. The control-path flag tells downstream logic to zero every control signal and so insert a bubble. The same cycle, it hands back the held instruction word and PC so that decode sees the same instruction again on the next cycle.

Top module: `loadhaz_unit`

## Requirements
- R1: When `idExMemRead` is 1, `idExRd` is nonzero and the IF/ID word has opcode (bits 6:0) 7'b0110011, all three hold outputs are 1 if `idExRd` equals bits 19:15 or bits 24:20 of the word.
- R2: The same hold is raised for a consumer with opcode 7'b0100011, using the same bits 19:15 and 24:20.
- R3: The same hold is raised for a consumer with opcode 7'b1100011, using the same bits 19:15 and 24:20.
- R4: When `idExMemRead` is 0, all three hold outputs are 0, whatever the other inputs are.
- R5: For any opcode other than the three above, the hold outputs are 0, even when bits 19:15 or 24:20 equal `idExRd`. This includes immediate ALU (7'b0010011), load, JALR and LUI opcodes.
- R6: When `idExRd` is 0, the hold outputs are 0.
- R7: `instHold`, `pcHold` and `ctrlHold` always carry the same value.
- R8: While the holds are 1, `instReplay` equals `ifIdInst` and `pcReplay` equals `ifIdPc`. While the holds are 0, both replay outputs are zero.
- R9: If `idExRd` matches neither bits 19:15 nor bits 24:20 of a register, store or branch consumer, the hold outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifIdInst | input | 32 | Instruction word in the fetch/decode register |
| ifIdPc | input | XLEN (32) | PC of that instruction |
| idExRd | input | 5 | Destination register index in the decode/execute register |
| idExMemRead | input | 1 | 1 when the decode/execute instruction is a load |
| instHold | output | 1 | Hold the instruction path |
| pcHold | output | 1 | Hold the PC path |
| ctrlHold | output | 1 | Zero the control signals (insert a bubble) |
| instReplay | output | 32 | Instruction to present to decode again |
| pcReplay | output | XLEN (32) | PC to present to decode again |

## Verification
No register lies between any input and any output, so every result is due in the same cycle as its stimulus. The bench changes inputs shortly after a rising edge and samples all five outputs at the next falling edge, half a period later, after the logic has settled. A single drive and sample pair then covers both the hold flags and the replay values. No check waits on a later clock edge.

// File: rtl/loadhaz_pkg.sv
package loadhaz_pkg;

  localparam int INST_W   = 32;
  localparam int REG_W    = 5;
  localparam int OPC_W    = 7;
  localparam int NUM_SRC  = 2;
  localparam int SRC1_LSB = 15;
  localparam int SRC2_LSB = 20;

  localparam logic [OPC_W-1:0] OPC_REGREG = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;

  typedef struct packed {
    logic instHold;
    logic pcHold;
    logic ctrlHold;
  } holdStrobes_t;

  function automatic int srcLsb(input int idx);
    return (idx == 0) ? SRC1_LSB : SRC2_LSB;
  endfunction

endpackage

// File: rtl/loadhaz_ctrl.sv
module loadhaz_ctrl
  import loadhaz_pkg::*;
(
  input  logic [INST_W-1:0] consumerInst,
  input  logic [REG_W-1:0]  producerRd,
  input  logic              producerIsLoad,
  output holdStrobes_t      strobes
);

  logic [OPC_W-1:0]   opcode;
  logic               readsTwoRegs;
  logic [NUM_SRC-1:0] srcHit;
  logic               rdLive;
  logic               hazard;

  assign opcode = consumerInst[OPC_W-1:0];

  always_comb begin
    unique case (opcode)
      OPC_REGREG, OPC_STORE, OPC_BRANCH: readsTwoRegs = 1'b1;
      default:                           readsTwoRegs = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int LSB = srcLsb(g);
    assign srcHit[g] = (consumerInst[LSB +: REG_W] == producerRd);
  end

  assign rdLive = |producerRd;
  assign hazard = producerIsLoad && rdLive && readsTwoRegs && (|srcHit);

  assign strobes.instHold = hazard;
  assign strobes.pcHold   = hazard;
  assign strobes.ctrlHold = hazard;

  always_comb begin
    p_load_required_r4: assert (producerIsLoad || !strobes.ctrlHold)
      else $error("hold raised without load in ID/EX");
  end

endmodule

// File: rtl/loadhaz_path.sv
module loadhaz_path
  import loadhaz_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic [INST_W-1:0] heldInst,
  input  logic [XLEN-1:0]   heldPc,
  input  holdStrobes_t      strobes,
  output logic [INST_W-1:0] instOut,
  output logic [XLEN-1:0]   pcOut
);

  for (genvar b = 0; b < INST_W; b++) begin : g_inst
    assign instOut[b] = heldInst[b] & strobes.instHold;
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_pc
    assign pcOut[b] = heldPc[b] & strobes.pcHold;
  end

  always_comb begin
    p_idle_zero_r8: assert (strobes.pcHold || (pcOut == '0))
      else $error("PC replay nonzero while not holding");
  end

endmodule

// File: rtl/loadhaz_unit.sv
module loadhaz_unit
  import loadhaz_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic [31:0]     ifIdInst,
  input  logic [XLEN-1:0] ifIdPc,
  input  logic [4:0]      idExRd,
  input  logic            idExMemRead,
  output logic            instHold,
  output logic            pcHold,
  output logic            ctrlHold,
  output logic [31:0]     instReplay,
  output logic [XLEN-1:0] pcReplay
);

  holdStrobes_t strobes;

  loadhaz_ctrl u_ctrl (
    .consumerInst  (ifIdInst),
    .producerRd    (idExRd),
    .producerIsLoad(idExMemRead),
    .strobes       (strobes)
  );

  loadhaz_path #(.XLEN(XLEN)) u_path (
    .heldInst(ifIdInst),
    .heldPc  (ifIdPc),
    .strobes (strobes),
    .instOut (instReplay),
    .pcOut   (pcReplay)
  );

  assign instHold = strobes.instHold;
  assign pcHold   = strobes.pcHold;
  assign ctrlHold = strobes.ctrlHold;

  always_comb begin
    p_holds_agree_r7: assert ((instHold == pcHold) && (pcHold == ctrlHold))
      else $error("hold flags disagree");
    p_replay_inst_r8: assert (!instHold || (instReplay == ifIdInst))
      else $error("instruction replay mismatch");
    p_replay_pc_r8: assert (!pcHold || (pcReplay == ifIdPc))
      else $error("PC replay mismatch");
    p_zero_rd_r6: assert ((idExRd != '0) || !ctrlHold)
      else $error("hold raised for x0 destination");
    p_consumer_class_r5: assert (ctrlHold == 1'b0 ||
                                 ifIdInst[6:0] == OPC_REGREG ||
                                 ifIdInst[6:0] == OPC_STORE ||
                                 ifIdInst[6:0] == OPC_BRANCH)
      else $error("hold raised for non-register consumer");
  end

endmodule

// File: tb/loadhaz_unit_test.sv
module loadhaz_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ifIdInst = '0;
  logic [31:0] ifIdPc = '0;
  logic [4:0]  idExRd = '0;
  logic        idExMemRead = 1'b0;
  logic        instHold, pcHold, ctrlHold;
  logic [31:0] instReplay, pcReplay;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  loadhaz_unit uut (
    .ifIdInst   (ifIdInst),
    .ifIdPc     (ifIdPc),
    .idExRd     (idExRd),
    .idExMemRead(idExMemRead),
    .instHold   (instHold),
    .pcHold     (pcHold),
    .ctrlHold   (ctrlHold),
    .instReplay (instReplay),
    .pcReplay   (pcReplay)
  );

  function automatic logic [31:0] encR(input logic [4:0] rs1, input logic [4:0] rs2, input logic [4:0] rd);
    return {7'b0, rs2, rs1, 3'b000, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] encS(input logic [4:0] rs1, input logic [4:0] rs2);
    return {7'b0, rs2, rs1, 3'b010, 5'b00100, 7'b0100011};
  endfunction
  function automatic logic [31:0] encB(input logic [4:0] rs1, input logic [4:0] rs2);
    return {7'b0, rs2, rs1, 3'b001, 5'b01000, 7'b1100011};
  endfunction
  function automatic logic [31:0] encI(input logic [4:0] rs1, input logic [11:0] imm, input logic [6:0] opc);
    return {imm, rs1, 3'b000, 5'd1, opc};
  endfunction

  typedef struct packed {
    logic [31:0] inst;
    logic [31:0] pc;
    logic [4:0]  rd;
    logic        memRd;
    logic        expHold;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{encR(5'd5, 5'd6, 5'd3),  32'h0000_0100, 5'd5,  1'b1, 1'b1, 4'd1},
    '{encR(5'd7, 5'd9, 5'd3),  32'h0000_0104, 5'd9,  1'b1, 1'b1, 4'd1},
    '{encS(5'd2, 5'd12),       32'h0000_0200, 5'd2,  1'b1, 1'b1, 4'd2},
    '{encS(5'd2, 5'd12),       32'h0000_0204, 5'd12, 1'b1, 1'b1, 4'd2},
    '{encB(5'd31, 5'd1),       32'h0000_0300, 5'd31, 1'b1, 1'b1, 4'd3},
    '{encB(5'd31, 5'd1),       32'h0000_0304, 5'd1,  1'b1, 1'b1, 4'd3},
    '{encR(5'd5, 5'd6, 5'd3),  32'h0000_0400, 5'd5,  1'b0, 1'b0, 4'd4},
    '{encB(5'd8, 5'd8),        32'h0000_0404, 5'd8,  1'b0, 1'b0, 4'd4},
    '{encI(5'd5, 12'h005, 7'b0010011), 32'h0000_0500, 5'd5, 1'b1, 1'b0, 4'd5},
    '{encI(5'd5, 12'h005, 7'b0000011), 32'h0000_0504, 5'd5, 1'b1, 1'b0, 4'd5},
    '{encI(5'd5, 12'h005, 7'b1100111), 32'h0000_0508, 5'd5, 1'b1, 1'b0, 4'd5},
    '{{20'h02825, 5'd1, 7'b0110111},   32'h0000_050c, 5'd5, 1'b1, 1'b0, 4'd5},
    '{encR(5'd0, 5'd0, 5'd3),  32'h0000_0600, 5'd0,  1'b1, 1'b0, 4'd6},
    '{encS(5'd0, 5'd4),        32'h0000_0604, 5'd0,  1'b1, 1'b0, 4'd6},
    '{encR(5'd5, 5'd6, 5'd5),  32'h0000_0700, 5'd7,  1'b1, 1'b0, 4'd9},
    '{encB(5'd10, 5'd11),      32'h0000_0704, 5'd26, 1'b1, 1'b0, 4'd9}
  };

  task automatic checkOut(input string tag, input logic expHold,
                          input logic [31:0] expInst, input logic [31:0] expPc);
    logic [2:0] expH;
    expH = {3{expHold}};
    checks++;
    if ({instHold, pcHold, ctrlHold} !== expH) begin
      failures++;
      $display("FAIL %s holds actual=%b expected=%b", tag, {instHold, pcHold, ctrlHold}, expH);
    end
    checks++;
    if (instReplay !== expInst || pcReplay !== expPc) begin
      failures++;
      $display("FAIL %s replay actual=%h/%h expected=%h/%h", tag, instReplay, pcReplay, expInst, expPc);
    end
  endtask

  task automatic apply(input logic [31:0] inst, input logic [31:0] pc,
                       input logic [4:0] rd, input logic memRd);
    @(posedge clk);
    #1;
    ifIdInst = inst;
    ifIdPc = pc;
    idExRd = rd;
    idExMemRead = memRd;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero inputs give no hold and zero replay (R4, R8)
    checkOut("R4 idle", 1'b0, 32'h0, 32'h0);
    rst = 1'b0;

    // table walk: R1, R2, R3, R4, R5, R6, R9 and replay values per R8
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      apply(VECS[i].inst, VECS[i].pc, VECS[i].rd, VECS[i].memRd);
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      checkOut(tag, VECS[i].expHold,
               VECS[i].expHold ? VECS[i].inst : 32'h0,
               VECS[i].expHold ? VECS[i].pc : 32'h0);
    end

    // R6: x0 destination never stalls, every consumer class
    apply(encB(5'd0, 5'd0), 32'hffff_fffc, 5'd0, 1'b1);
    checkOut("R6 branch x0", 1'b0, 32'h0, 32'h0);

    // R4: memRead low across every register index, reg-reg consumer matching
    for (int r = 1; r < 32; r++) begin
      apply(encR(5'(r), 5'(r), 5'd2), 32'h1000 + 32'(r), 5'(r), 1'b0);
      checkOut("R4 sweep", 1'b0, 32'h0, 32'h0);
    end

    // R1, R8: every nonzero index stalls, replay carries full-width values
    for (int r = 1; r < 32; r++) begin
      apply(encR(5'(r), 5'd0, 5'd2), 32'hdead_0000 | 32'(r), 5'(r), 1'b1);
      checkOut("R1 sweep", 1'b1, encR(5'(r), 5'd0, 5'd2), 32'hdead_0000 | 32'(r));
    end

    // R7, R8: hold drops back to zero replay right after a stall
    apply(encS(5'd3, 5'd4), 32'h8000_0000, 5'd4, 1'b1);
    checkOut("R8 stall", 1'b1, encS(5'd3, 5'd4), 32'h8000_0000);
    apply(encS(5'd3, 5'd4), 32'h8000_0000, 5'd4, 1'b0);
    checkOut("R7 release", 1'b0, 32'h0, 32'h0);

    // R5: immediate-ALU consumer whose imm bits 24:20 equal rd
    apply(encI(5'd1, 12'h00f, 7'b0010011), 32'h44, 5'd15, 1'b1);
    checkOut("R5 imm field", 1'b0, 32'h0, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule